// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block brings a digitally regulated supply up in a controlled way. A selectable enable source starts it. The source can be a hardware pin, a software bit, both together, or an always-on mode that follows the core-supply-good signal. The block first waits a programmable turn-on delay. It then ramps an internal digital reference from a start value to the nominal setpoint. All timing counts ticks of an internal strobe, which fires once every `TICK_CYC` clock cycles.

Before the ramp begins, the block picks the regulation point: the local sense input or the remote sense input. The start value is either zero or the sensed voltage at that point (precharge start). A precharge start uses the same slope, so a partly charged output finishes the ramp sooner. During the ramp the block can hand regulation over to the remote sense input and close the output switch. It clears an undervoltage flag, and it raises power-good after a debounce once the ramp has finished and no fault is present.

Dropping the enable returns the sequencer to idle at any point.

Top module: `softstart_seq`

## Requirements
- R1: The enable source is chosen by `on_mode`: 00 follows `core_ok`, 01 follows `pin_on`, 10 follows `sw_on`, and 11 needs both `pin_on` and `sw_on` high.
- R2: When the enable is seen, the sequencer waits `dly_code*DLY_STEP` ticks before `ramp_active` rises. With code 0 the ramp starts two cycles after the enable.
- R3: Ramp code k gives a full ramp of N = (5 + floor(95*k/7)) * TICKS_PER_MS ticks. Starting from zero, `ref_o` reaches `vnom` exactly at the end of the ramp, and `ss_done` rises the cycle after.
- R4: Each tick the reference grows by q or q+1, where q = floor(vnom/N). The remainder is spread evenly, and the reference never decreases or exceeds `vnom`.
- R5: With `pre_en` set, the ramp starts from the sensed voltage at the chosen regulation point, capped at `vnom`. It uses the same per-tick step as a full ramp, so it ends sooner. With `pre_en` clear it starts from 0.
- R6: At ramp start, regulation begins on the remote sense input (`reg_remote`=1) when `force_remote` is set or `vs_local >= vs_bus`. Otherwise it begins on the local sense input.
- R7: While ramping or done on the local sense input, `vs_local >= sw_thr` sets both `reg_remote` and `oring_on`. Both then hold until disable.
- R8: With `force_remote` set at ramp start, regulation is remote and `oring_on` stays low.
- R9: `uv_flag` is 1 in idle. It clears after enable once the top 7 bits of `vs_local` exceed `uv_lim`, and it stays clear until disable.
- R10: `pgood` rises after `db_code*DB_STEP` ticks in the done state with `fault_in` low and `uv_flag` clear. Any fault or undervoltage drops it and restarts the debounce.
- R11: Dropping the enable returns the sequencer to idle in the next cycle: reference 0, `pgood` low, local regulation, switch open, `uv_flag` set.
- R12: After reset, `ref_o` is 0, `uv_flag` is 1, and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_mode | input | 2 | Enable source select |
| core_ok | input | 1 | Core supply above undervoltage lockout |
| pin_on | input | 1 | Hardware on request |
| sw_on | input | 1 | Software on request |
| dly_code | input | 2 | Turn-on delay code |
| ramp_code | input | 3 | Full ramp time code |
| pre_en | input | 1 | Start ramp from sensed voltage |
| force_remote | input | 1 | Always regulate on the remote sense input |
| vnom | input | REF_W | Nominal setpoint |
| vs_local | input | REF_W | Local output sense |
| vs_bus | input | REF_W | Bus-side sense beyond the output switch |
| vs_remote | input | REF_W | Remote sense |
| sw_thr | input | REF_W | Output-switch enable threshold |
| uv_lim | input | UV_W | Undervoltage limit |
| db_code | input | 4 | Power-good debounce code |
| fault_in | input | 1 | Other fault present |
| ref_o | output | REF_W | Digital reference |
| ramp_active | output | 1 | Ramp in progress |
| ss_done | output | 1 | Ramp finished |
| reg_remote | output | 1 | Regulating on the remote sense input |
| oring_on | output | 1 | Output switch closed |
| uv_flag | output | 1 | Undervoltage flag |
| pgood | output | 1 | Power good |

## Verification
The hardest case to reach is the mid-ramp handover. It needs the local sense voltage to cross the switch threshold while the reference is still climbing. The bench drives `vs_local` from `ref_o` on every cycle, like a regulated output tracking its reference, so the handover and the undervoltage clear happen on their own partway up. A behavioural model that recomputes the same handover, debounce and remainder spreading is compared with every output on every clock. Further runs add a disable mid-ramp, a precharged start with a measured ramp length, a forced remote start, and a fault pulse during the debounce.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_DELAY = 2'd1,
      SQ_RAMP  = 2'd2,
      SQ_DONE  = 2'd3
   } sq_state_t;

   // Full ramp length in milliseconds for a 3-bit code: 5 ms .. 100 ms in eight steps
   function automatic int ramp_ms(input logic [2:0] code);
      return 5 + (95 * int'(code)) / 7;
   endfunction
endpackage

// File: rtl/ssq_timebase.sv
module ssq_timebase #(
   parameter int TICK_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_CYC < 1) begin : g_bad_cyc
         $error("ssq_timebase: TICK_CYC must be at least 1");
      end
      if (TICK_CYC == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int TCW = $clog2(TICK_CYC);
         logic [TCW-1:0] cnt_q;
         assign tick = (cnt_q == TCW'(TICK_CYC - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (tick) cnt_q <= '0;
            else           cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/ssq_step.sv
module ssq_step #(
   parameter int REF_W = 12,
   parameter int NW    = 7
) (
   input  logic [REF_W-1:0] ref_cur,
   input  logic [NW-1:0]    acc_cur,
   input  logic [REF_W-1:0] q_step,
   input  logic [NW-1:0]    r_step,
   input  logic [NW-1:0]    n_len,
   input  logic [REF_W-1:0] tgt,
   output logic [REF_W-1:0] ref_nxt,
   output logic [NW-1:0]    acc_nxt
);
   logic [NW:0]    acc_sum;
   logic           carry;
   logic [REF_W:0] ref_sum;

   always_comb begin
      acc_sum = {1'b0, acc_cur} + {1'b0, r_step};
      carry   = (acc_sum >= {1'b0, n_len});
      acc_nxt = carry ? NW'(acc_sum - {1'b0, n_len}) : acc_sum[NW-1:0];
      ref_sum = {1'b0, ref_cur} + {1'b0, q_step} + {{REF_W{1'b0}}, carry};
      ref_nxt = (ref_sum >= {1'b0, tgt}) ? tgt : ref_sum[REF_W-1:0];
   end
endmodule

// File: rtl/ssq_pgood.sv
module ssq_pgood #(
   parameter int DBW = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           hold_off,
   input  logic           tick,
   input  logic [DBW-1:0] target,
   output logic           pg
);
   logic [DBW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pg    <= 1'b0;
      end else if (clr || hold_off) begin
         cnt_q <= '0;
         pg    <= 1'b0;
      end else if (cnt_q == target) begin
         pg    <= 1'b1;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R10: power-good never rises while the hold-off condition is present
   p_pg_needs_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_off || clr) |=> !pg);
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
   import ssq_pkg::*;
#(
   parameter int REF_W        = 12,
   parameter int UV_W         = 7,
   parameter int TICK_CYC     = 2,
   parameter int TICKS_PER_MS = 1,
   parameter int DLY_STEP     = 4,
   parameter int DB_STEP      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       on_mode,
   input  logic             core_ok,
   input  logic             pin_on,
   input  logic             sw_on,
   input  logic [1:0]       dly_code,
   input  logic [2:0]       ramp_code,
   input  logic             pre_en,
   input  logic             force_remote,
   input  logic [REF_W-1:0] vnom,
   input  logic [REF_W-1:0] vs_local,
   input  logic [REF_W-1:0] vs_bus,
   input  logic [REF_W-1:0] vs_remote,
   input  logic [REF_W-1:0] sw_thr,
   input  logic [UV_W-1:0]  uv_lim,
   input  logic [3:0]       db_code,
   input  logic             fault_in,
   output logic [REF_W-1:0] ref_o,
   output logic             ramp_active,
   output logic             ss_done,
   output logic             reg_remote,
   output logic             oring_on,
   output logic             uv_flag,
   output logic             pgood
);
   localparam int NMAX = 100 * TICKS_PER_MS;
   localparam int NW   = $clog2(NMAX + 1);
   localparam int DW   = (REF_W > NW) ? REF_W : NW;
   localparam int DCW  = $clog2(3 * DLY_STEP + 1);
   localparam int DBW  = $clog2(15 * DB_STEP + 1);

   generate
      if (UV_W > REF_W) begin : g_bad_uv
         $error("softstart_seq: UV_W must not exceed REF_W");
      end
      if (TICKS_PER_MS < 1 || DLY_STEP < 1 || DB_STEP < 1) begin : g_bad_step
         $error("softstart_seq: tick scaling parameters must be positive");
      end
   endgenerate

   sq_state_t        state_q;
   logic [DCW-1:0]   dcnt_q;
   logic [REF_W-1:0] ref_q, tgt_q, q_q;
   logic [NW-1:0]    acc_q, r_q, n_q;
   logic             remote_q, oring_q, uv_q;
   logic             tick, en;

   ssq_timebase #(.TICK_CYC(TICK_CYC)) u_tb (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   // Enable source select
   always_comb begin
      unique case (on_mode)
         2'b00:   en = core_ok;
         2'b01:   en = pin_on;
         2'b10:   en = sw_on;
         default: en = pin_on & sw_on;
      endcase
   end

   // Ramp start decisions
   logic             start_remote;
   logic [REF_W-1:0] sensed, start_val;
   logic [NW-1:0]    n_full;
   logic [DW-1:0]    div_q, div_r;

   always_comb begin
      start_remote = force_remote || (vs_local >= vs_bus);
      sensed       = start_remote ? vs_remote : vs_local;
      start_val    = pre_en ? ((sensed > vnom) ? vnom : sensed) : '0;
      n_full       = NW'(ramp_ms(ramp_code) * TICKS_PER_MS);
      div_q        = DW'(vnom) / DW'(n_full);
      div_r        = DW'(vnom) % DW'(n_full);
   end

   logic [REF_W-1:0] ref_step;
   logic [NW-1:0]    acc_step;

   ssq_step #(.REF_W(REF_W), .NW(NW)) u_step (
      .ref_cur(ref_q), .acc_cur(acc_q), .q_step(q_q), .r_step(r_q),
      .n_len(n_q), .tgt(tgt_q), .ref_nxt(ref_step), .acc_nxt(acc_step)
   );

   logic uv_above, handover;
   assign uv_above = (vs_local[REF_W-1 -: UV_W] > uv_lim);
   assign handover = ((state_q == SQ_RAMP) || (state_q == SQ_DONE)) &&
                     !remote_q && (vs_local >= sw_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         dcnt_q   <= '0;
         ref_q    <= '0;
         acc_q    <= '0;
         tgt_q    <= '0;
         q_q      <= '0;
         r_q      <= '0;
         n_q      <= NW'(5);
         remote_q <= 1'b0;
         oring_q  <= 1'b0;
         uv_q     <= 1'b1;
      end else if (!en) begin
         state_q  <= SQ_IDLE;
         dcnt_q   <= '0;
         ref_q    <= '0;
         acc_q    <= '0;
         remote_q <= 1'b0;
         oring_q  <= 1'b0;
         uv_q     <= 1'b1;
      end else begin
         if (state_q != SQ_IDLE && uv_above) uv_q <= 1'b0;
         if (handover) begin
            remote_q <= 1'b1;
            oring_q  <= 1'b1;
         end
         unique case (state_q)
            SQ_IDLE: begin
               state_q <= SQ_DELAY;
               dcnt_q  <= DCW'(dly_code) * DCW'(DLY_STEP);
            end
            SQ_DELAY: begin
               if (dcnt_q == '0) begin
                  state_q  <= SQ_RAMP;
                  ref_q    <= start_val;
                  acc_q    <= '0;
                  tgt_q    <= vnom;
                  n_q      <= n_full;
                  q_q      <= div_q[REF_W-1:0];
                  r_q      <= div_r[NW-1:0];
                  remote_q <= start_remote;
                  oring_q  <= start_remote & ~force_remote;
               end else if (tick) begin
                  dcnt_q <= dcnt_q - 1'b1;
               end
            end
            SQ_RAMP: begin
               if (ref_q >= tgt_q) begin
                  state_q <= SQ_DONE;
               end else if (tick) begin
                  ref_q <= ref_step;
                  acc_q <= acc_step;
               end
            end
            default: ;
         endcase
      end
   end

   ssq_pgood #(.DBW(DBW)) u_pg (
      .clk(clk), .rst_n(rst_n),
      .clr(!en || (state_q != SQ_DONE)),
      .hold_off(fault_in || uv_q),
      .tick(tick),
      .target(DBW'(db_code) * DBW'(DB_STEP)),
      .pg(pgood)
   );

   assign ref_o       = ref_q;
   assign ramp_active = (state_q == SQ_RAMP);
   assign ss_done     = (state_q == SQ_DONE);
   assign reg_remote  = remote_q;
   assign oring_on    = oring_q;
   assign uv_flag     = uv_q;

   // R4: reference never passes the captured target
   p_ref_capped_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_RAMP || state_q == SQ_DONE) |-> (ref_q <= tgt_q));

   // R4: during the ramp each update is non-decreasing and at most q+1
   p_step_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_RAMP && $past(state_q) == SQ_RAMP) |->
      ((ref_q >= $past(ref_q)) &&
       ({1'b0, ref_q} - {1'b0, $past(ref_q)} <= {1'b0, q_q} + 1'b1)));

   // R11: disable returns everything to idle on the next edge
   p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state_q == SQ_IDLE && ref_q == '0 && !pgood && uv_q && !remote_q));

   // R7: remote regulation holds while enabled
   p_remote_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (remote_q && en) |=> remote_q);

   // R8: forced remote at ramp start leaves the switch open
   p_force_remote_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_RAMP && $past(state_q) == SQ_DELAY && $past(force_remote))
      |-> (remote_q && !oring_q));

   // R9: undervoltage flag stays clear once cleared while enabled
   p_uv_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!uv_q && en) |=> !uv_q);

   // R10: power-good only in the done state
   p_pg_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pgood |-> (state_q == SQ_DONE));
endmodule

// File: tb/tb_softstart_seq.sv
module tb_softstart_seq;
   localparam int REF_W = 12, UV_W = 7, TICK_CYC = 2, TPM = 1, DLY_STEP = 4, DB_STEP = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic [1:0] on_mode = 2'b01;
   logic core_ok = 0, pin_on = 0, sw_on = 0, pre_en = 0, force_remote = 0, fault_in = 0;
   logic [1:0] dly_code = 0;
   logic [2:0] ramp_code = 0;
   logic [REF_W-1:0] vnom = 1000, vs_local = 0, vs_bus = 4095, vs_remote = 0, sw_thr = 800;
   logic [UV_W-1:0] uv_lim = 10;
   logic [3:0] db_code = 3;
   logic [REF_W-1:0] ref_o;
   logic ramp_active, ss_done, reg_remote, oring_on, uv_flag, pgood;

   softstart_seq #(.REF_W(REF_W), .UV_W(UV_W), .TICK_CYC(TICK_CYC), .TICKS_PER_MS(TPM),
                   .DLY_STEP(DLY_STEP), .DB_STEP(DB_STEP)) dut (
      .clk(clk), .rst_n(rst_n), .on_mode(on_mode), .core_ok(core_ok), .pin_on(pin_on),
      .sw_on(sw_on), .dly_code(dly_code), .ramp_code(ramp_code), .pre_en(pre_en),
      .force_remote(force_remote), .vnom(vnom), .vs_local(vs_local), .vs_bus(vs_bus),
      .vs_remote(vs_remote), .sw_thr(sw_thr), .uv_lim(uv_lim), .db_code(db_code),
      .fault_in(fault_in), .ref_o(ref_o), .ramp_active(ramp_active), .ss_done(ss_done),
      .reg_remote(reg_remote), .oring_on(oring_on), .uv_flag(uv_flag), .pgood(pgood));

   always #10 clk = ~clk;   // 50 MHz

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit track = 0;
   int ramp_cycles = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic int ramp_len(input int k);
      return (5 + (95 * k) / 7) * TPM;
   endfunction

   // ---------------- behavioural reference model ----------------
   int m_tc = 0, m_st = 0, m_ref = 0, m_acc = 0, m_tgt = 0, m_n = 5, m_q = 0, m_r = 0;
   int m_dc = 0, m_db = 0;
   bit m_rem = 0, m_or = 0, m_uv = 1, m_pg = 0;

   always @(posedge clk) begin
      bit tk, en_i, o_rem, o_uv, rem0, c;
      int o_st, sens, s;
      if (!rst_n) begin
         m_tc = 0; m_st = 0; m_ref = 0; m_acc = 0; m_dc = 0; m_db = 0;
         m_rem = 0; m_or = 0; m_uv = 1; m_pg = 0;
      end else begin
         tk = (m_tc == TICK_CYC - 1);
         m_tc = tk ? 0 : m_tc + 1;
         case (on_mode)
            2'b00: en_i = core_ok;
            2'b01: en_i = pin_on;
            2'b10: en_i = sw_on;
            default: en_i = pin_on && sw_on;
         endcase
         if (!en_i) begin
            m_st = 0; m_ref = 0; m_acc = 0; m_dc = 0; m_db = 0;
            m_rem = 0; m_or = 0; m_uv = 1; m_pg = 0;
         end else begin
            o_st = m_st; o_rem = m_rem; o_uv = m_uv;
            if (o_st != 3 || fault_in || o_uv) begin m_db = 0; m_pg = 0; end
            else if (m_db == db_code * DB_STEP) m_pg = 1;
            else if (tk) m_db++;
            if (o_st != 0 && (int'(vs_local) >> (REF_W - UV_W)) > uv_lim) m_uv = 0;
            if ((o_st == 2 || o_st == 3) && !o_rem && vs_local >= sw_thr) begin
               m_rem = 1; m_or = 1;
            end
            case (o_st)
               0: begin m_st = 1; m_dc = dly_code * DLY_STEP; end
               1: if (m_dc == 0) begin
                     rem0 = force_remote || (vs_local >= vs_bus);
                     sens = rem0 ? vs_remote : vs_local;
                     m_ref = pre_en ? ((sens > vnom) ? int'(vnom) : sens) : 0;
                     m_tgt = vnom; m_n = ramp_len(ramp_code);
                     m_q = m_tgt / m_n; m_r = m_tgt % m_n; m_acc = 0;
                     m_rem = rem0; m_or = rem0 && !force_remote; m_st = 2;
                  end else if (tk) m_dc--;
               2: if (m_ref >= m_tgt) m_st = 3;
                  else if (tk) begin
                     m_acc += m_r; c = (m_acc >= m_n); if (c) m_acc -= m_n;
                     s = m_ref + m_q + int'(c);
                     m_ref = (s >= m_tgt) ? m_tgt : s;
                  end
               default: ;
            endcase
         end
      end
   end

   // Compare every output on every clock, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (cyc > 2) begin
         chk(ref_o == m_ref, "R3/R4 ref_o", ref_o, m_ref);
         chk(ramp_active == (m_st == 2), "R2 ramp_active", ramp_active, m_st == 2);
         chk(ss_done == (m_st == 3), "R3 ss_done", ss_done, m_st == 3);
         chk(reg_remote == m_rem, "R6/R7 reg_remote", reg_remote, m_rem);
         chk(oring_on == m_or, "R7/R8 oring_on", oring_on, m_or);
         chk(uv_flag == m_uv, "R9 uv_flag", uv_flag, m_uv);
         chk(pgood == m_pg, "R10 pgood", pgood, m_pg);
      end
      if (ramp_active) ramp_cycles++;
      if (track) vs_local = ref_o;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_done(input int lim);
      for (int i = 0; i < lim && !ss_done; i++) @(negedge clk);
   endtask

   initial begin
      int full_len, pre_len;
      #1 rst_n = 1'b0;
      cycles(3);
      // R12: reset state
      chk(ref_o == 0 && !ramp_active && !ss_done && !reg_remote && !oring_on && !pgood,
          "R12 reset outputs", ref_o, 0);
      chk(uv_flag == 1, "R12 reset uv_flag", uv_flag, 1);
      rst_n = 1'b1;
      cycles(4);

      // R1: mode 11 with only one request stays idle
      on_mode = 2'b11; pin_on = 1; sw_on = 0; dly_code = 0;
      cycles(20);
      chk(!ramp_active && !ss_done, "R1 mode 11 single request", ramp_active, 0);
      pin_on = 0; sw_on = 1;
      cycles(20);
      chk(!ramp_active && !ss_done, "R1 mode 11 single request", ramp_active, 0);
      sw_on = 0;

      // R1 R2 R3 R6 R7 R9 R10: always-on mode, local start, tracking output, handover
      on_mode = 2'b00; core_ok = 0; dly_code = 2; ramp_code = 3; vnom = 1000;
      vs_bus = 4095; sw_thr = 800; track = 1; db_code = 3;
      cycles(10);
      chk(!ramp_active, "R1 core_ok low keeps idle", ramp_active, 0);
      core_ok = 1;
      cycles(3);
      chk(!ramp_active, "R2 delay in progress", ramp_active, 0);
      wait_done(400);
      chk(ref_o == vnom, "R3 ramp end equals setpoint", ref_o, vnom);
      chk(reg_remote && oring_on, "R7 handover happened", reg_remote, 1);
      chk(!uv_flag, "R9 uv cleared", uv_flag, 0);
      cycles(20);
      chk(pgood, "R10 pgood after debounce", pgood, 1);
      fault_in = 1; cycles(3);
      chk(!pgood, "R10 fault drops pgood", pgood, 0);
      fault_in = 0; cycles(20);
      chk(pgood, "R10 pgood recovers", pgood, 1);
      core_ok = 0; cycles(2);
      chk(ref_o == 0 && !pgood && uv_flag && !reg_remote, "R11 disable to idle", ref_o, 0);
      track = 0; vs_local = 0;

      // R3: full ramp length from zero, code 7, pin mode
      on_mode = 2'b01; dly_code = 0; ramp_code = 7; vs_bus = 4095; sw_thr = 4095;
      ramp_cycles = 0; pin_on = 1;
      wait_done(600);
      full_len = ramp_cycles;
      chk(ref_o == vnom, "R3 code 7 end value", ref_o, vnom);
      chk(full_len >= ramp_len(7) * TICK_CYC && full_len <= ramp_len(7) * TICK_CYC + 2,
          "R3 full ramp length", full_len, ramp_len(7) * TICK_CYC);

      // R11: disable mid-ramp
      pin_on = 0; cycles(3);
      pin_on = 1; cycles(60);
      chk(ramp_active && ref_o > 0 && ref_o < vnom, "R11 mid-ramp reached", ref_o, 0);
      pin_on = 0; cycles(2);
      chk(ref_o == 0 && !ramp_active, "R11 mid-ramp disable", ref_o, 0);

      // R5 R6: precharge from remote sense, software mode
      on_mode = 2'b10; pre_en = 1; vs_local = 600; vs_bus = 100; vs_remote = 500;
      ramp_cycles = 0; sw_on = 1;
      cycles(3);
      chk(ref_o == 500 && reg_remote && oring_on, "R5/R6 precharge start", ref_o, 500);
      wait_done(600);
      pre_len = ramp_cycles;
      chk(pre_len < full_len && pre_len >= 48 * TICK_CYC, "R5 shorter ramp", pre_len, 50 * TICK_CYC);
      sw_on = 0; cycles(2);

      // R5: precharge above setpoint is capped
      vs_remote = 2000; sw_on = 1; cycles(4);
      chk(ref_o == vnom, "R5 capped start", ref_o, vnom);
      sw_on = 0; cycles(2);

      // R8: forced remote, switch stays open
      on_mode = 2'b11; pre_en = 0; force_remote = 1; vs_local = 0; vs_bus = 4000;
      sw_thr = 10; ramp_code = 0; vnom = 777;
      pin_on = 1; sw_on = 1;
      wait_done(300);
      chk(reg_remote && !oring_on, "R8 forced remote", oring_on, 0);
      chk(ref_o == 777, "R3 code 0 end value", ref_o, 777);
      pin_on = 0; sw_on = 0; force_remote = 0; cycles(4);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule